// File: doc/BRIEF.md
# Partition Freeze State and Access Gate

This block keeps the isolation state of every partition group behind a PCIe host bridge and applies it to the traffic that passes through. Each group owns two frozen flags. One covers memory-mapped accesses started by the CPU. The other covers traffic started by devices: DMA reads, DMA writes and MSIs. When an error handler raises a freeze event for a group, both flags go up together. Software can later release either flag without touching the other, for example to reopen MMIO for diagnosis while DMA stays fenced.

Two independent request paths pass through the gate, one for CPU-side requests and one for device-side requests. Every request carries a group number. A request whose group is not frozen on its path is forwarded one cycle later with its payload unchanged. A request whose group is frozen is never forwarded. The gate answers it locally one cycle later: a dropped write or MSI gets a bare completion, and a dropped read gets all-ones data. The requester therefore always receives an answer. A small configuration port lets software set or clear the flags of any group and read the flag pair of any group.

Top module: `part_freeze_gate`

## Requirements
- R1: After reset, every group reads back flag pair 2'b00 on `cfg_rd_flags`, and no request is blocked.
- R2: A freeze event on group g sets both flags of g at the clock edge where `frz_vld` is sampled. The other groups are unaffected.
- R3: A software clear (`cfg_clr` bit 0 for MMIO, bit 1 for DMA) releases only the selected flag of `cfg_grp`. The other flag keeps its value.
- R4: When a freeze event and a software clear hit the same group in the same cycle, both flags of that group end up set.
- R5: A software set (`cfg_set`, with the same bit positions as `cfg_clr`) sets the selected flags. If set and clear select the same bit, the set wins.
- R6: A request whose group has its path flag clear appears on the forward outputs one cycle later with unchanged direction, address, data and MSI marker. No local completion is produced for it.
- R7: A CPU write to a group with its MMIO flag set is not forwarded. One cycle later a local completion appears with data zero.
- R8: A CPU read from a group with its MMIO flag set is not forwarded. One cycle later a local completion appears with data of all ones.
- R9: A device read or write from a group with its DMA flag set is dropped in the same way. A read completes with all ones and a write completes with zero.
- R10: An MSI (`dma_req_msi`=1) from a group with its DMA flag set is never forwarded. It receives a local completion.
- R11: The gating decision uses the flag values held before the clock edge. A freeze event or flag update in the same cycle as a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_vld | input | 1 | Freeze event strobe |
| frz_grp | input | GRP_W | Group to freeze |
| cfg_we | input | 1 | Software flag update strobe |
| cfg_grp | input | GRP_W | Group addressed by the update |
| cfg_set | input | 2 | Flags to set (bit0 MMIO, bit1 DMA) |
| cfg_clr | input | 2 | Flags to clear (bit0 MMIO, bit1 DMA) |
| cfg_rd_grp | input | GRP_W | Group whose flags are read |
| cfg_rd_flags | output | 2 | Flag pair of `cfg_rd_grp` (bit0 MMIO, bit1 DMA) |
| cpu_req_vld | input | 1 | CPU request valid |
| cpu_req_grp | input | GRP_W | CPU request group |
| cpu_req_wr | input | 1 | CPU request is a write |
| cpu_req_addr | input | AW | CPU request address |
| cpu_req_wdata | input | DW | CPU write data |
| cpu_fwd_vld | output | 1 | Forwarded CPU request valid |
| cpu_fwd_wr | output | 1 | Forwarded CPU request is a write |
| cpu_fwd_addr | output | AW | Forwarded CPU address |
| cpu_fwd_wdata | output | DW | Forwarded CPU write data |
| cpu_cpl_vld | output | 1 | Local completion for a dropped CPU request |
| cpu_cpl_rdata | output | DW | Local completion data |
| dma_req_vld | input | 1 | Device request valid |
| dma_req_grp | input | GRP_W | Device request group |
| dma_req_wr | input | 1 | Device request is a write |
| dma_req_msi | input | 1 | Device request is an MSI |
| dma_req_addr | input | AW | Device request address |
| dma_req_wdata | input | DW | Device write data |
| dma_fwd_vld | output | 1 | Forwarded device request valid |
| dma_fwd_wr | output | 1 | Forwarded device request is a write |
| dma_fwd_msi | output | 1 | Forwarded device request is an MSI |
| dma_fwd_addr | output | AW | Forwarded device address |
| dma_fwd_wdata | output | DW | Forwarded device write data |
| dma_cpl_vld | output | 1 | Local completion for a dropped device request |
| dma_cpl_rdata | output | DW | Local completion data |

## Verification
The bench builds the block with 8 groups, 16-bit addresses and 32-bit data. With only 8 groups, random traffic hits every group often. This brings within reach the collisions between freeze events, software clears and requests on the same group in the same cycle, which would be rare with the full 256 groups. The narrow address and data keep the payload comparison cheap. The all-ones read value is still wide enough to tell it apart from forwarded data.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   // Position of each flag in a flag pair.
   localparam int FLAG_MMIO = 0;
   localparam int FLAG_DMA  = 1;

   typedef logic [1:0] flag_pair_t;

   // Next value of one flag pair.
   // Clear applies first, software set overrides it, and a freeze overrides both.
   function automatic flag_pair_t flag_next(input flag_pair_t cur,
                                            input flag_pair_t set_m,
                                            input flag_pair_t clr_m,
                                            input logic       frz);
      flag_pair_t n;
      n = (cur & ~clr_m) | set_m;
      if (frz) n = 2'b11;
      return n;
   endfunction

endpackage

// File: rtl/pfg_flag_bank.sv
module pfg_flag_bank
   import pfg_pkg::*;
#(
   parameter int NUM_GRP = 256,
   parameter int GRP_W   = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frz_vld,
   input  logic [GRP_W-1:0]   frz_grp,
   input  logic               cfg_we,
   input  logic [GRP_W-1:0]   cfg_grp,
   input  logic [1:0]         cfg_set,
   input  logic [1:0]         cfg_clr,
   output logic [NUM_GRP-1:0] mmio_q,
   output logic [NUM_GRP-1:0] dma_q
);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic       frz_hit;
      logic       cfg_hit;
      flag_pair_t cur;
      flag_pair_t nxt;

      assign frz_hit = frz_vld && (frz_grp == GRP_W'(g));
      assign cfg_hit = cfg_we  && (cfg_grp == GRP_W'(g));
      assign cur     = {dma_q[g], mmio_q[g]};
      assign nxt     = flag_next(cur,
                                 cfg_hit ? cfg_set : 2'b00,
                                 cfg_hit ? cfg_clr : 2'b00,
                                 frz_hit);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mmio_q[g] <= 1'b0;
            dma_q[g]  <= 1'b0;
         end else begin
            mmio_q[g] <= nxt[FLAG_MMIO];
            dma_q[g]  <= nxt[FLAG_DMA];
         end
      end
   end

endmodule

// File: rtl/pfg_path_gate.sv
module pfg_path_gate #(
   parameter int PW = 48,
   parameter int DW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic          in_wr,
   input  logic [PW-1:0] in_pay,
   input  logic          frozen,
   output logic          fwd_vld,
   output logic          fwd_wr,
   output logic [PW-1:0] fwd_pay,
   output logic          cpl_vld,
   output logic [DW-1:0] cpl_rdata
);

   logic pass;
   logic drop;

   assign pass = in_vld && !frozen;
   assign drop = in_vld &&  frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_vld   <= 1'b0;
         cpl_vld   <= 1'b0;
         cpl_rdata <= '0;
      end else begin
         fwd_vld   <= pass;
         cpl_vld   <= drop;
         cpl_rdata <= (drop && !in_wr) ? '1 : '0;
      end
   end

   // The payload is held only when a request is accepted, which saves toggling on idle cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_wr  <= 1'b0;
         fwd_pay <= '0;
      end else if (pass) begin
         fwd_wr  <= in_wr;
         fwd_pay <= in_pay;
      end
   end

endmodule

// File: rtl/part_freeze_gate.sv
module part_freeze_gate
   import pfg_pkg::*;
#(
   parameter int NUM_GRP = 256,
   parameter int AW      = 48,
   parameter int DW      = 64,
   localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frz_vld,
   input  logic [GRP_W-1:0] frz_grp,
   input  logic             cfg_we,
   input  logic [GRP_W-1:0] cfg_grp,
   input  logic [1:0]       cfg_set,
   input  logic [1:0]       cfg_clr,
   input  logic [GRP_W-1:0] cfg_rd_grp,
   output logic [1:0]       cfg_rd_flags,
   input  logic             cpu_req_vld,
   input  logic [GRP_W-1:0] cpu_req_grp,
   input  logic             cpu_req_wr,
   input  logic [AW-1:0]    cpu_req_addr,
   input  logic [DW-1:0]    cpu_req_wdata,
   output logic             cpu_fwd_vld,
   output logic             cpu_fwd_wr,
   output logic [AW-1:0]    cpu_fwd_addr,
   output logic [DW-1:0]    cpu_fwd_wdata,
   output logic             cpu_cpl_vld,
   output logic [DW-1:0]    cpu_cpl_rdata,
   input  logic             dma_req_vld,
   input  logic [GRP_W-1:0] dma_req_grp,
   input  logic             dma_req_wr,
   input  logic             dma_req_msi,
   input  logic [AW-1:0]    dma_req_addr,
   input  logic [DW-1:0]    dma_req_wdata,
   output logic             dma_fwd_vld,
   output logic             dma_fwd_wr,
   output logic             dma_fwd_msi,
   output logic [AW-1:0]    dma_fwd_addr,
   output logic [DW-1:0]    dma_fwd_wdata,
   output logic             dma_cpl_vld,
   output logic [DW-1:0]    dma_cpl_rdata
);

   localparam int CPU_PW = AW + DW;
   localparam int DMA_PW = 1 + AW + DW;

   if (NUM_GRP < 2 || NUM_GRP > 256) begin : g_bad_grp
      $error("part_freeze_gate: NUM_GRP must lie in 2..256");
   end
   if ((NUM_GRP & (NUM_GRP - 1)) != 0) begin : g_bad_pow2
      $error("part_freeze_gate: NUM_GRP must be a power of two");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("part_freeze_gate: AW and DW must be positive");
   end

   logic [NUM_GRP-1:0] mmio_q;
   logic [NUM_GRP-1:0] dma_q;

   pfg_flag_bank #(
      .NUM_GRP (NUM_GRP),
      .GRP_W   (GRP_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .frz_vld (frz_vld),
      .frz_grp (frz_grp),
      .cfg_we  (cfg_we),
      .cfg_grp (cfg_grp),
      .cfg_set (cfg_set),
      .cfg_clr (cfg_clr),
      .mmio_q  (mmio_q),
      .dma_q   (dma_q)
   );

   assign cfg_rd_flags[FLAG_MMIO] = mmio_q[cfg_rd_grp];
   assign cfg_rd_flags[FLAG_DMA]  = dma_q[cfg_rd_grp];

   // CPU-side path, gated by the MMIO flag.
   logic [CPU_PW-1:0] cpu_pay_in;
   logic [CPU_PW-1:0] cpu_pay_out;

   assign cpu_pay_in = {cpu_req_addr, cpu_req_wdata};

   pfg_path_gate #(
      .PW (CPU_PW),
      .DW (DW)
   ) u_cpu_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (cpu_req_vld),
      .in_wr     (cpu_req_wr),
      .in_pay    (cpu_pay_in),
      .frozen    (mmio_q[cpu_req_grp]),
      .fwd_vld   (cpu_fwd_vld),
      .fwd_wr    (cpu_fwd_wr),
      .fwd_pay   (cpu_pay_out),
      .cpl_vld   (cpu_cpl_vld),
      .cpl_rdata (cpu_cpl_rdata)
   );

   assign {cpu_fwd_addr, cpu_fwd_wdata} = cpu_pay_out;

   // Device-side path, gated by the DMA flag. MSIs are treated as writes.
   logic [DMA_PW-1:0] dma_pay_in;
   logic [DMA_PW-1:0] dma_pay_out;
   logic              dma_is_wr;

   assign dma_pay_in = {dma_req_msi, dma_req_addr, dma_req_wdata};
   assign dma_is_wr  = dma_req_wr || dma_req_msi;

   pfg_path_gate #(
      .PW (DMA_PW),
      .DW (DW)
   ) u_dma_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (dma_req_vld),
      .in_wr     (dma_is_wr),
      .in_pay    (dma_pay_in),
      .frozen    (dma_q[dma_req_grp]),
      .fwd_vld   (dma_fwd_vld),
      .fwd_wr    (dma_fwd_wr),
      .fwd_pay   (dma_pay_out),
      .cpl_vld   (dma_cpl_vld),
      .cpl_rdata (dma_cpl_rdata)
   );

   assign {dma_fwd_msi, dma_fwd_addr, dma_fwd_wdata} = dma_pay_out;

endmodule

// File: rtl/part_freeze_gate_chk.sv
module part_freeze_gate_chk #(
   parameter int NUM_GRP = 256,
   parameter int DW      = 64,
   localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
)(
   input logic               clk,
   input logic               rst_n,
   input logic               frz_vld,
   input logic [GRP_W-1:0]   frz_grp,
   input logic               cfg_we,
   input logic [GRP_W-1:0]   cfg_grp,
   input logic [1:0]         cfg_set,
   input logic [1:0]         cfg_clr,
   input logic               cpu_req_vld,
   input logic [GRP_W-1:0]   cpu_req_grp,
   input logic               cpu_req_wr,
   input logic               cpu_fwd_vld,
   input logic               cpu_cpl_vld,
   input logic [DW-1:0]      cpu_cpl_rdata,
   input logic               dma_req_vld,
   input logic [GRP_W-1:0]   dma_req_grp,
   input logic               dma_req_msi,
   input logic               dma_fwd_vld,
   input logic               dma_cpl_vld,
   input logic [NUM_GRP-1:0] mmio_q,
   input logic [NUM_GRP-1:0] dma_q
);

   // R2: a freeze event raises both flags of its group.
   a_r2_freeze_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
      frz_vld |=> (mmio_q[$past(frz_grp)] && dma_q[$past(frz_grp)]));

   // R3: a clear of the MMIO flag alone leaves the DMA flag untouched.
   a_r3_clear_mmio_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_clr == 2'b01 && cfg_set == 2'b00 && !frz_vld)
      |=> (!mmio_q[$past(cfg_grp)] && dma_q[$past(cfg_grp)] == $past(dma_q[cfg_grp])));

   // R4: a freeze beats a software clear aimed at the same group.
   a_r4_freeze_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_vld && cfg_we && cfg_grp == frz_grp) |=> (mmio_q[$past(cfg_grp)] && dma_q[$past(cfg_grp)]));

   // R6: forwarding and local completion never occur together on a path.
   a_r6_cpu_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_fwd_vld && cpu_cpl_vld));

   // R7: a request to an MMIO-frozen group is answered locally and not forwarded.
   a_r7_cpu_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_vld && mmio_q[cpu_req_grp]) |=> (cpu_cpl_vld && !cpu_fwd_vld));

   // R8: a read from an MMIO-frozen group completes with all ones.
   a_r8_cpu_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_vld && !cpu_req_wr && mmio_q[cpu_req_grp]) |=> (cpu_cpl_rdata == {DW{1'b1}}));

   // R10: an MSI from a DMA-frozen group is blocked but still completed.
   a_r10_msi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req_vld && dma_req_msi && dma_q[dma_req_grp]) |=> (!dma_fwd_vld && dma_cpl_vld));

   // R6: an unfrozen device request is forwarded.
   a_r6_dma_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req_vld && !dma_q[dma_req_grp]) |=> (dma_fwd_vld && !dma_cpl_vld));

endmodule

bind part_freeze_gate part_freeze_gate_chk #(
   .NUM_GRP (NUM_GRP),
   .DW      (DW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frz_vld       (frz_vld),
   .frz_grp       (frz_grp),
   .cfg_we        (cfg_we),
   .cfg_grp       (cfg_grp),
   .cfg_set       (cfg_set),
   .cfg_clr       (cfg_clr),
   .cpu_req_vld   (cpu_req_vld),
   .cpu_req_grp   (cpu_req_grp),
   .cpu_req_wr    (cpu_req_wr),
   .cpu_fwd_vld   (cpu_fwd_vld),
   .cpu_cpl_vld   (cpu_cpl_vld),
   .cpu_cpl_rdata (cpu_cpl_rdata),
   .dma_req_vld   (dma_req_vld),
   .dma_req_grp   (dma_req_grp),
   .dma_req_msi   (dma_req_msi),
   .dma_fwd_vld   (dma_fwd_vld),
   .dma_cpl_vld   (dma_cpl_vld),
   .mmio_q        (mmio_q),
   .dma_q         (dma_q)
);

// File: tb/test_part_freeze_gate.sv
`timescale 1ns/1ps
module test_part_freeze_gate;

   localparam int NG = 8;
   localparam int GW = 3;
   localparam int AW = 16;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          frz_vld = 0;
   logic [GW-1:0] frz_grp = 0;
   logic          cfg_we = 0;
   logic [GW-1:0] cfg_grp = 0;
   logic [1:0]    cfg_set = 0, cfg_clr = 0;
   logic [GW-1:0] cfg_rd_grp = 0;
   logic [1:0]    cfg_rd_flags;
   logic          cpu_req_vld = 0, cpu_req_wr = 0;
   logic [GW-1:0] cpu_req_grp = 0;
   logic [AW-1:0] cpu_req_addr = 0;
   logic [DW-1:0] cpu_req_wdata = 0;
   logic          cpu_fwd_vld, cpu_fwd_wr, cpu_cpl_vld;
   logic [AW-1:0] cpu_fwd_addr;
   logic [DW-1:0] cpu_fwd_wdata, cpu_cpl_rdata;
   logic          dma_req_vld = 0, dma_req_wr = 0, dma_req_msi = 0;
   logic [GW-1:0] dma_req_grp = 0;
   logic [AW-1:0] dma_req_addr = 0;
   logic [DW-1:0] dma_req_wdata = 0;
   logic          dma_fwd_vld, dma_fwd_wr, dma_fwd_msi, dma_cpl_vld;
   logic [AW-1:0] dma_fwd_addr;
   logic [DW-1:0] dma_fwd_wdata, dma_cpl_rdata;

   part_freeze_gate #(.NUM_GRP(NG), .AW(AW), .DW(DW)) i_part_freeze_gate (.*);

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference model: flag arrays and the expected registered outputs.
   bit          m_mmio [NG];
   bit          m_dma  [NG];
   bit          e_cfwd, e_cwr, e_ccpl, e_dfwd, e_dwr, e_dmsi, e_dcpl;
   logic [AW-1:0] e_caddr, e_daddr;
   logic [DW-1:0] e_cdata, e_crd, e_ddata, e_drd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_mmio[i]) begin m_mmio[i] = 0; m_dma[i] = 0; end
         e_cfwd = 0; e_ccpl = 0; e_dfwd = 0; e_dcpl = 0;
         e_crd = 0; e_drd = 0;
      end else begin
         e_cfwd = cpu_req_vld && !m_mmio[cpu_req_grp];
         e_ccpl = cpu_req_vld &&  m_mmio[cpu_req_grp];
         e_crd  = (e_ccpl && !cpu_req_wr) ? '1 : '0;
         if (e_cfwd) begin e_cwr = cpu_req_wr; e_caddr = cpu_req_addr; e_cdata = cpu_req_wdata; end
         e_dfwd = dma_req_vld && !m_dma[dma_req_grp];
         e_dcpl = dma_req_vld &&  m_dma[dma_req_grp];
         e_drd  = (e_dcpl && !dma_req_wr && !dma_req_msi) ? '1 : '0;
         if (e_dfwd) begin
            e_dwr = dma_req_wr || dma_req_msi; e_dmsi = dma_req_msi;
            e_daddr = dma_req_addr; e_ddata = dma_req_wdata;
         end
         if (cfg_we) begin
            if (cfg_clr[0]) m_mmio[cfg_grp] = 0;
            if (cfg_clr[1]) m_dma[cfg_grp]  = 0;
            if (cfg_set[0]) m_mmio[cfg_grp] = 1;
            if (cfg_set[1]) m_dma[cfg_grp]  = 1;
         end
         if (frz_vld) begin m_mmio[frz_grp] = 1; m_dma[frz_grp] = 1; end
      end
   end

   // Compare against the model on every falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 R3 flags vs model", cfg_rd_flags, {m_dma[cfg_rd_grp], m_mmio[cfg_rd_grp]});
         chk("R6 cpu fwd vld vs model", cpu_fwd_vld, e_cfwd);
         if (e_cfwd) chk("R6 cpu fwd payload vs model",
                         {cpu_fwd_wr, cpu_fwd_addr, cpu_fwd_wdata}, {e_cwr, e_caddr, e_cdata});
         chk("R7 R8 cpu cpl vs model", {cpu_cpl_vld, cpu_cpl_rdata}, {e_ccpl, e_crd});
         chk("R6 dma fwd vld vs model", dma_fwd_vld, e_dfwd);
         if (e_dfwd) chk("R10 dma fwd payload vs model",
                         {dma_fwd_wr, dma_fwd_msi, dma_fwd_addr, dma_fwd_wdata},
                         {e_dwr, e_dmsi, e_daddr, e_ddata});
         chk("R9 dma cpl vs model", {dma_cpl_vld, dma_cpl_rdata}, {e_dcpl, e_drd});
      end
   end

   task automatic cyc(); @(posedge clk); #5; endtask

   task automatic idle();
      frz_vld = 0; cfg_we = 0; cfg_set = 0; cfg_clr = 0;
      cpu_req_vld = 0; dma_req_vld = 0; dma_req_msi = 0;
   endtask

   // Apply the current stimulus for one edge, then sample at the following falling edge.
   task automatic apply_and_settle(); cyc(); idle(); #5; endtask

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1;
      cyc();

      // R1: all groups clear after reset.
      for (int g = 0; g < NG; g++) begin
         cfg_rd_grp = GW'(g); #1;
         chk("R1 reset flags", cfg_rd_flags, 2'b00);
      end
      cpu_req_vld = 1; cpu_req_grp = 5; cpu_req_wr = 0; cpu_req_addr = 16'h00a0;
      apply_and_settle();
      chk("R1 no block after reset", {cpu_fwd_vld, cpu_cpl_vld}, 2'b10);

      // R2: freeze group 3.
      cyc(); frz_vld = 1; frz_grp = 3;
      apply_and_settle();
      cfg_rd_grp = 3; #1; chk("R2 freeze sets both", cfg_rd_flags, 2'b11);
      cfg_rd_grp = 2; #1; chk("R2 neighbour untouched", cfg_rd_flags, 2'b00);

      // R8 and R7: CPU read and write to the frozen group.
      cyc(); cpu_req_vld = 1; cpu_req_grp = 3; cpu_req_wr = 0; cpu_req_addr = 16'h1234;
      apply_and_settle();
      chk("R8 frozen read", {cpu_fwd_vld, cpu_cpl_vld, cpu_cpl_rdata}, {2'b01, 32'hffff_ffff});
      cyc(); cpu_req_vld = 1; cpu_req_grp = 3; cpu_req_wr = 1; cpu_req_wdata = 32'hdead_beef;
      apply_and_settle();
      chk("R7 frozen write", {cpu_fwd_vld, cpu_cpl_vld, cpu_cpl_rdata}, {2'b01, 32'h0});

      // R3: clear only MMIO of group 3.
      cyc(); cfg_we = 1; cfg_grp = 3; cfg_clr = 2'b01;
      apply_and_settle();
      cfg_rd_grp = 3; #1; chk("R3 mmio cleared dma kept", cfg_rd_flags, 2'b10);

      // R6: CPU read now forwarded.
      cyc(); cpu_req_vld = 1; cpu_req_grp = 3; cpu_req_wr = 0; cpu_req_addr = 16'h4321;
      apply_and_settle();
      chk("R6 forward after clear", {cpu_fwd_vld, cpu_cpl_vld, cpu_fwd_addr}, {2'b10, 16'h4321});

      // R9: device read and write still dropped.
      cyc(); dma_req_vld = 1; dma_req_grp = 3; dma_req_wr = 0;
      apply_and_settle();
      chk("R9 dma frozen read", {dma_fwd_vld, dma_cpl_vld, dma_cpl_rdata}, {2'b01, 32'hffff_ffff});
      cyc(); dma_req_vld = 1; dma_req_grp = 3; dma_req_wr = 1;
      apply_and_settle();
      chk("R9 dma frozen write", {dma_fwd_vld, dma_cpl_vld, dma_cpl_rdata}, {2'b01, 32'h0});

      // R10: MSI blocked.
      cyc(); dma_req_vld = 1; dma_req_grp = 3; dma_req_wr = 0; dma_req_msi = 1;
      apply_and_settle();
      chk("R10 msi blocked", {dma_fwd_vld, dma_cpl_vld}, 2'b01);

      // R4: freeze and clear on group 6 in the same cycle.
      cyc(); frz_vld = 1; frz_grp = 6; cfg_we = 1; cfg_grp = 6; cfg_clr = 2'b11;
      apply_and_settle();
      cfg_rd_grp = 6; #1; chk("R4 freeze beats clear", cfg_rd_flags, 2'b11);

      // R5: software set of DMA only on group 1, then set wins over clear.
      cyc(); cfg_we = 1; cfg_grp = 1; cfg_set = 2'b10;
      apply_and_settle();
      cfg_rd_grp = 1; #1; chk("R5 set dma", cfg_rd_flags, 2'b10);
      cyc(); cfg_we = 1; cfg_grp = 1; cfg_set = 2'b01; cfg_clr = 2'b01;
      apply_and_settle();
      cfg_rd_grp = 1; #1; chk("R5 set beats clear", cfg_rd_flags, 2'b11);

      // R11: freeze group 4 and send a request to it in the same cycle.
      cyc(); frz_vld = 1; frz_grp = 4; cpu_req_vld = 1; cpu_req_grp = 4; cpu_req_wr = 1;
      apply_and_settle();
      chk("R11 same-cycle request passes", {cpu_fwd_vld, cpu_cpl_vld}, 2'b10);

      // Random traffic checked against the model.
      for (int n = 0; n < 3000; n++) begin
         cyc();
         frz_vld       = ($urandom_range(15) == 0);
         frz_grp       = GW'($urandom);
         cfg_we        = ($urandom_range(3) == 0);
         cfg_grp       = GW'($urandom);
         cfg_set       = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00;
         cfg_clr       = 2'($urandom);
         cfg_rd_grp    = GW'($urandom);
         cpu_req_vld   = $urandom_range(1);
         cpu_req_grp   = GW'($urandom);
         cpu_req_wr    = $urandom_range(1);
         cpu_req_addr  = AW'($urandom);
         cpu_req_wdata = $urandom;
         dma_req_vld   = $urandom_range(1);
         dma_req_grp   = GW'($urandom);
         dma_req_wr    = $urandom_range(1);
         dma_req_msi   = ($urandom_range(3) == 0);
         dma_req_addr  = AW'($urandom);
         dma_req_wdata = $urandom;
      end
      cyc(); idle();
      repeat (2) cyc();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule